// File: doc/BRIEF.md
# Host Bus Cycle Register Router

This block sits behind the asynchronous host port of a wide associative memory device. Each host access is framed by an active-low chip enable. The block classifies the access by two select lines into one of four cycle kinds and commits it when chip enable rises. It then points the access at exactly one internal register. It holds the routing state the host relies on:

- default targets for command cycles;
- a one-shot override that diverts a single command cycle;
- an address-follow flag that diverts the command write straight after an instruction;
- a toggling status-half pointer;
- a persistent source and a persistent destination for data cycles.

The registers behind the router are kept as plain storage so that each route can be seen from the bus. The memory array, the match logic and instruction execution live elsewhere. The next-free pointer is written only by that outside logic, through a dedicated update strobe. The 32-bit status word is an input.

All inputs are taken as synchronous to `clk`. An access is the span of clocks with `ce_n` low. The select lines and the write data are captured on every clock of that span, and the last captured values are used. The access commits on the first clock edge that sees `ce_n` high again.

Top module: `hostbus_router`

## Requirements
- R1: While `ce_n` is high, `bus_oe` is low. While `ce_n` is low, `bus_oe` equals `wr_n`, and `dq_o` is zero whenever `bus_oe` is low.
- R2: The cycle kind is encoded as `{cd_sel, wr_n}`: 00 command write, 01 command read, 10 data write, 11 data read. A write commits during the clock in which `ce_n` has just gone high, and pulses at most one `load_sel` bit. A read drives at most one `rd_sel` bit while `ce_n` is low and never pulses `load_sel`. The bit positions are: 1 instruction, 2 address, 3 control, 4 segment control, 5 next-free, 6 status low half, 7 status high half, 8 source-select word, 9 destination-select word, 10 comparand, 11 mask one, 12 mask two.
- R3: With no override or address flag pending, a command write loads the instruction register.
- R4: If the instruction just loaded has bit 11 set, the immediately following cycle, if it is a command write, loads the address register. Any other cycle in between cancels the flag.
- R5: An instruction whose bits 15:12 are 1 arms an override. Its bits 3:0 select the target: 1 address, 2 control, 3 segment control, 4 next-free, 5 source-select word, 6 destination-select word. Exactly the next command cycle, read or write, uses that register, and routing then returns to the defaults. Data cycles leave a pending override untouched.
- R6: The next-free register resets to zero. It is readable through the override. A command write under an override naming it, or naming either select word, loads nothing.
- R7: A command read without an override returns status bits 15:0. If it directly follows a command read of bits 15:0, it returns bits 31:16.
- R8: Any cycle other than a command read returns the status pointer to bits 15:0.
- R9: After reset the comparand is both the data source and the data destination. An instruction with bits 15:12 equal to 2 selects the source, and one with bits 15:12 equal to 3 selects the destination. In both, bits 1:0 give 0 comparand, 1 mask one, 2 mask two. The code 3 is ignored and leaves the selection unchanged.
- R10: A command read under an override naming the source-select or destination-select word returns the whole instruction that last changed that selection, or zero if none has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low; rising edge ends an access |
| cd_sel | input | 1 | 0 command cycle, 1 data cycle |
| wr_n | input | 1 | 0 write, 1 read |
| dq_i | input | 16 | Write data from the host bus |
| stat_i | input | 32 | Status word supplied by the core |
| nfa_set | input | 1 | Update strobe for the next-free register from the core |
| nfa_val | input | 16 | Next-free value written on `nfa_set` |
| dq_o | output | 16 | Read data toward the host bus |
| bus_oe | output | 1 | Bus output enable |
| load_sel | output | 13 | One-hot load strobe per register at write commit |
| rd_sel | output | 13 | One-hot read select during a read access |

## Verification
The checker watches four things on every cycle:
- the output enable against chip enable;
- the one-hot shape and commit timing of the load strobes;
- the rule that a comparand or mask read only ever comes from a data cycle;
- the rule that the high status half appears only right after a low-half read.

It also confirms that the next-free register never receives a bus load. The bench scenarios show behaviour that depends on instruction history. This covers the address-follow flag and its cancellation, the single-use override across every target, and persistent source and destination selection including the ignored code. It also covers read-back of the selecting instruction words and the data actually stored behind each route.

// File: rtl/hbr_pkg.sv
// Package: shared cycle kinds, register target codes and instruction field
// decoding for the host bus router. Assumes 16-bit instruction words.
package hbr_pkg;

    typedef enum logic [1:0] {
        CYC_CMD_WR = 2'b00,
        CYC_CMD_RD = 2'b01,
        CYC_DAT_WR = 2'b10,
        CYC_DAT_RD = 2'b11
    } cyc_e;

    typedef enum logic [3:0] {
        T_NONE  = 4'd0,
        T_INSTR = 4'd1,
        T_ADDR  = 4'd2,
        T_CTRL  = 4'd3,
        T_SEGC  = 4'd4,
        T_NFA   = 4'd5,
        T_STLO  = 4'd6,
        T_STHI  = 4'd7,
        T_PSID  = 4'd8,
        T_PDID  = 4'd9,
        T_COMP  = 4'd10,
        T_MSK1  = 4'd11,
        T_MSK2  = 4'd12
    } tgt_e;

    localparam int NTGT    = 13;
    localparam int WORD_W  = 16;
    localparam int AF_BIT  = 11;
    localparam int OP_LSB  = 12;
    localparam logic [3:0] OP_OVR  = 4'h1;
    localparam logic [3:0] OP_PSRC = 4'h2;
    localparam logic [3:0] OP_PDST = 4'h3;

    // Override target field to register code
    function automatic tgt_e ovr_code(input logic [3:0] f);
        case (f)
            4'd1:    return T_ADDR;
            4'd2:    return T_CTRL;
            4'd3:    return T_SEGC;
            4'd4:    return T_NFA;
            4'd5:    return T_PSID;
            4'd6:    return T_PDID;
            default: return T_NONE;
        endcase
    endfunction

    // Persistent select field to data register code
    function automatic tgt_e pers_code(input logic [1:0] f);
        case (f)
            2'd0:    return T_COMP;
            2'd1:    return T_MSK1;
            2'd2:    return T_MSK2;
            default: return T_NONE;
        endcase
    endfunction

    // Registers that hold bus-written storage
    function automatic logic is_storable(input int idx);
        return (idx == int'(T_INSTR)) || (idx == int'(T_ADDR)) ||
               (idx == int'(T_CTRL))  || (idx == int'(T_SEGC)) ||
               (idx == int'(T_COMP))  || (idx == int'(T_MSK1)) ||
               (idx == int'(T_MSK2));
    endfunction

endpackage

// File: rtl/hbr_cycle_sense.sv
// Cycle sense: frames a host access by chip enable, captures the selects and
// write data on every clock of the access and flags the commit clock (first
// clock with chip enable high again). Assumes inputs synchronous to clk.
module hbr_cycle_sense
    import hbr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          cd_sel,
    input  logic          wr_n,
    input  logic [DW-1:0] dq_i,
    output cyc_e          live_kind,
    output cyc_e          cap_kind,
    output logic [DW-1:0] cap_data,
    output logic          cyc_end
);

    logic ce_q;

    // Delay chip enable by one clock to find its rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) ce_q <= 1'b1;
        else        ce_q <= ce_n;
    end

    // Capture the access attributes while the access is open
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_kind <= CYC_CMD_RD;
            cap_data <= '0;
        end else if (!ce_n) begin
            cap_kind <= cyc_e'({cd_sel, wr_n});
            cap_data <= dq_i;
        end
    end

    assign live_kind = cyc_e'({cd_sel, wr_n});
    assign cyc_end   = ce_n & ~ce_q;

endmodule

// File: rtl/hbr_cmd_route.sv
// Command routing: resolves the register for command cycles from defaults,
// the address-follow flag, a single-use override and the status-half
// pointer, and updates that state on each committed cycle.
// Assumes kind is the live kind during an access and the captured kind at commit.
module hbr_cmd_route
    import hbr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_end,
    input  cyc_e          kind,
    input  logic [DW-1:0] wdata,
    output tgt_e          cmd_tgt,
    output logic          ins_commit
);

    logic       ovr_pend;
    tgt_e       ovr_tgt;
    logic       af_pend;
    logic       st_hi;
    logic [3:0] opcode;
    tgt_e       new_ovr;

    assign opcode  = wdata[OP_LSB +: 4];
    assign new_ovr = ovr_code(wdata[3:0]);

    // Choose the command target for the current kind
    always_comb begin
        cmd_tgt = T_NONE;
        if (kind == CYC_CMD_WR) begin
            if (ovr_pend)
                cmd_tgt = (ovr_tgt == T_NFA || ovr_tgt == T_PSID || ovr_tgt == T_PDID)
                          ? T_NONE : ovr_tgt;
            else if (af_pend)
                cmd_tgt = T_ADDR;
            else
                cmd_tgt = T_INSTR;
        end else if (kind == CYC_CMD_RD) begin
            if (ovr_pend)   cmd_tgt = ovr_tgt;
            else if (st_hi) cmd_tgt = T_STHI;
            else            cmd_tgt = T_STLO;
        end
    end

    assign ins_commit = cyc_end && (kind == CYC_CMD_WR) && (cmd_tgt == T_INSTR);

    // Override arm and consume
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_pend <= 1'b0;
            ovr_tgt  <= T_NONE;
        end else if (cyc_end) begin
            if (ins_commit && opcode == OP_OVR && new_ovr != T_NONE) begin
                ovr_pend <= 1'b1;
                ovr_tgt  <= new_ovr;
            end else if (kind == CYC_CMD_WR || kind == CYC_CMD_RD) begin
                ovr_pend <= 1'b0;
            end
        end
    end

    // Address-follow flag lives for exactly one following cycle
    always_ff @(posedge clk) begin
        if (!rst_n)       af_pend <= 1'b0;
        else if (cyc_end) af_pend <= ins_commit && wdata[AF_BIT];
    end

    // Status-half pointer: high only after a low-half read
    always_ff @(posedge clk) begin
        if (!rst_n)       st_hi <= 1'b0;
        else if (cyc_end) st_hi <= (kind == CYC_CMD_RD) && (cmd_tgt == T_STLO);
    end

endmodule

// File: rtl/hbr_data_route.sv
// Data routing: holds the persistent source and destination for data cycles
// and the instruction words that last changed each of them.
// Assumes ins_commit marks an instruction being loaded at commit.
module hbr_data_route
    import hbr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_commit,
    input  logic [DW-1:0] ins_word,
    input  cyc_e          kind,
    output tgt_e          dat_tgt,
    output logic [DW-1:0] src_word,
    output logic [DW-1:0] dst_word
);

    tgt_e       psrc;
    tgt_e       pdst;
    logic [3:0] opcode;
    tgt_e       pick;

    assign opcode = ins_word[OP_LSB +: 4];
    assign pick   = pers_code(ins_word[1:0]);

    // Persistent source selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psrc     <= T_COMP;
            src_word <= '0;
        end else if (ins_commit && opcode == OP_PSRC && pick != T_NONE) begin
            psrc     <= pick;
            src_word <= ins_word;
        end
    end

    // Persistent destination selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdst     <= T_COMP;
            dst_word <= '0;
        end else if (ins_commit && opcode == OP_PDST && pick != T_NONE) begin
            pdst     <= pick;
            dst_word <= ins_word;
        end
    end

    // Data target for the current kind
    always_comb begin
        case (kind)
            CYC_DAT_WR: dat_tgt = pdst;
            CYC_DAT_RD: dat_tgt = psrc;
            default:    dat_tgt = T_NONE;
        endcase
    end

endmodule

// File: rtl/hbr_reg_store.sv
// Register storage: plain holding registers behind the router plus the read
// multiplexer. Next-free is written only by the core strobe.
module hbr_reg_store
    import hbr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  tgt_e          wr_tgt,
    input  logic [DW-1:0] wdata,
    input  logic          nfa_set,
    input  logic [DW-1:0] nfa_val,
    input  logic [2*DW-1:0] stat_i,
    input  logic [DW-1:0] src_word,
    input  logic [DW-1:0] dst_word,
    input  tgt_e          rd_tgt,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] slot [NTGT];
    logic [DW-1:0] nfa_q;

    for (genvar i = 0; i < NTGT; i++) begin : g_slot
        if (is_storable(i)) begin : g_reg
            logic [DW-1:0] q;
            // Load this register when the bus write targets it
            always_ff @(posedge clk) begin
                if (!rst_n)                            q <= '0;
                else if (wr_en && wr_tgt == tgt_e'(i)) q <= wdata;
            end
            assign slot[i] = q;
        end else begin : g_nil
            assign slot[i] = '0;
        end
    end

    // Next-free register updated by the core only
    always_ff @(posedge clk) begin
        if (!rst_n)       nfa_q <= '0;
        else if (nfa_set) nfa_q <= nfa_val;
    end

    // Read multiplexer
    always_comb begin
        case (rd_tgt)
            T_NFA:   rdata = nfa_q;
            T_STLO:  rdata = stat_i[DW-1:0];
            T_STHI:  rdata = stat_i[2*DW-1:DW];
            T_PSID:  rdata = src_word;
            T_PDID:  rdata = dst_word;
            default: rdata = slot[rd_tgt];
        endcase
    end

endmodule

// File: rtl/hostbus_router.sv
// Top: decodes each host access into a cycle kind, resolves the target
// register through command and data routing, drives one-hot load and read
// selects and the bus output enable. Assumes inputs synchronous to clk.
module hostbus_router
    import hbr_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int NT = NTGT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce_n,
    input  logic            cd_sel,
    input  logic            wr_n,
    input  logic [DW-1:0]   dq_i,
    input  logic [2*DW-1:0] stat_i,
    input  logic            nfa_set,
    input  logic [DW-1:0]   nfa_val,
    output logic [DW-1:0]   dq_o,
    output logic            bus_oe,
    output logic [NT-1:0]   load_sel,
    output logic [NT-1:0]   rd_sel
);

    cyc_e          live_kind, cap_kind, act_kind;
    logic [DW-1:0] cap_data, rdata, src_word, dst_word;
    logic          cyc_end, ins_commit, wr_commit;
    tgt_e          cmd_tgt, dat_tgt, tgt;

    hbr_cycle_sense #(.DW(DW)) u_sense (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cd_sel(cd_sel), .wr_n(wr_n),
        .dq_i(dq_i), .live_kind(live_kind), .cap_kind(cap_kind),
        .cap_data(cap_data), .cyc_end(cyc_end)
    );

    assign act_kind = cyc_end ? cap_kind : live_kind;

    hbr_cmd_route #(.DW(DW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cyc_end(cyc_end), .kind(act_kind),
        .wdata(cap_data), .cmd_tgt(cmd_tgt), .ins_commit(ins_commit)
    );

    hbr_data_route #(.DW(DW)) u_dat (
        .clk(clk), .rst_n(rst_n), .ins_commit(ins_commit), .ins_word(cap_data),
        .kind(act_kind), .dat_tgt(dat_tgt), .src_word(src_word), .dst_word(dst_word)
    );

    assign tgt       = act_kind[1] ? dat_tgt : cmd_tgt;
    assign wr_commit = cyc_end && !act_kind[0] && (tgt != T_NONE);

    hbr_reg_store #(.DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_commit), .wr_tgt(tgt),
        .wdata(cap_data), .nfa_set(nfa_set), .nfa_val(nfa_val), .stat_i(stat_i),
        .src_word(src_word), .dst_word(dst_word), .rd_tgt(tgt), .rdata(rdata)
    );

    // Drive one-hot selects and the bus output
    always_comb begin
        load_sel = '0;
        rd_sel   = '0;
        if (wr_commit)
            load_sel[tgt] = 1'b1;
        if (!ce_n && wr_n && tgt != T_NONE)
            rd_sel[tgt] = 1'b1;
    end

    assign bus_oe = !ce_n && wr_n;
    assign dq_o   = bus_oe ? rdata : '0;

endmodule

// File: rtl/hostbus_router_chk.sv
// Checker: cycle-by-cycle properties of the router ports, bound to the top.
module hostbus_router_chk
    import hbr_pkg::*;
#(
    parameter int NT = NTGT
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          cd_sel,
    input logic          bus_oe,
    input logic [NT-1:0] load_sel,
    input logic [NT-1:0] rd_sel
);

    logic ce_d, lo_seen, last_lo;

    // Track whether the last committed access read the low status half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_d    <= 1'b1;
            lo_seen <= 1'b0;
            last_lo <= 1'b0;
        end else begin
            ce_d <= ce_n;
            if (ce_n && !ce_d) begin
                last_lo <= lo_seen;
                lo_seen <= 1'b0;
            end else if (rd_sel[T_STLO]) begin
                lo_seen <= 1'b1;
            end
        end
    end

    // R1
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !bus_oe);

    // R2
    load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_sel) && $onehot0(rd_sel));

    // R2
    load_at_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_sel != '0) |-> (ce_n && !ce_d));

    // R6
    nfa_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_sel[T_NFA]);

    // R7
    status_hi_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel[T_STHI] |-> last_lo);

    // R9
    data_read_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel[T_COMP] || rd_sel[T_MSK1] || rd_sel[T_MSK2]) |-> cd_sel);

endmodule

bind hostbus_router hostbus_router_chk #(.NT(NT)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cd_sel(cd_sel),
    .bus_oe(bus_oe), .load_sel(load_sel), .rd_sel(rd_sel)
);

// File: tb/hostbus_router_tb.sv
// Bench: scenario sweeps over override targets, persistent selections and
// status sequences; expected values computed from the requirements.
module hostbus_router_tb;

    localparam int CLK_P = 10;
    localparam logic [31:0] STAT = 32'hBEEF_1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, cd_sel = 1'b0, wr_n = 1'b1, nfa_set = 1'b0;
    logic [15:0] dq_i = '0, nfa_val = '0, dq_o;
    logic [31:0] stat_i = STAT;
    logic        bus_oe;
    logic [12:0] load_sel, rd_sel;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic [15:0] r_q;
    logic [12:0] r_rs, r_ls;
    logic        r_oe;

    always #(CLK_P/2) clk = ~clk;

    hostbus_router u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cd_sel(cd_sel), .wr_n(wr_n),
        .dq_i(dq_i), .stat_i(stat_i), .nfa_set(nfa_set), .nfa_val(nfa_val),
        .dq_o(dq_o), .bus_oe(bus_oe), .load_sel(load_sel), .rd_sel(rd_sel)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One complete access: open, sample mid-access, close, sample commit
    task automatic cyc(input logic cd, input logic wr, input logic [15:0] d);
        @(negedge clk); ce_n = 1'b0; cd_sel = cd; wr_n = wr; dq_i = d;
        @(negedge clk); #1; r_q = dq_o; r_rs = rd_sel; r_oe = bus_oe;
        @(negedge clk); ce_n = 1'b1; #1; r_ls = load_sel;
        @(posedge clk);
    endtask

    function automatic logic [12:0] bit_of(input int i);
        return 13'(1) << i;
    endfunction

    task automatic cw(input logic [15:0] d, input int exp_bit, input string tag);
        cyc(1'b0, 1'b0, d);
        chk(r_ls == (exp_bit < 0 ? 13'd0 : bit_of(exp_bit)), tag, 32'(r_ls),
            32'(exp_bit < 0 ? 13'd0 : bit_of(exp_bit)));
    endtask

    task automatic cr(input logic [15:0] exp_q, input int exp_bit, input string tag);
        cyc(1'b0, 1'b1, 16'h0);
        chk(r_q == exp_q, tag, 32'(r_q), 32'(exp_q));
        chk(r_rs == bit_of(exp_bit) && r_ls == 13'd0, tag, 32'(r_rs), 32'(bit_of(exp_bit)));
    endtask

    task automatic dw(input logic [15:0] d, input int exp_bit, input string tag);
        cyc(1'b1, 1'b0, d);
        chk(r_ls == bit_of(exp_bit), tag, 32'(r_ls), 32'(bit_of(exp_bit)));
    endtask

    task automatic dr(input logic [15:0] exp_q, input int exp_bit, input string tag);
        cyc(1'b1, 1'b1, 16'h0);
        chk(r_q == exp_q && r_rs == bit_of(exp_bit), tag, {r_q, 3'b0, r_rs}, {exp_q, 3'b0, bit_of(exp_bit)});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset and deselect state
        chk(bus_oe == 1'b0 && load_sel == 0 && rd_sel == 0, "R1 reset", {bus_oe, load_sel, rd_sel}, 0);

        // R7 status toggle, R8 restore after other cycles
        cr(STAT[15:0], 6, "R7 first read low");
        chk(r_oe == 1'b1, "R1 oe on read", 32'(r_oe), 1);
        cr(STAT[31:16], 7, "R7 second read high");
        cr(STAT[15:0], 6, "R7 third read low");
        cw(16'h0000, 1, "R3 default write");
        chk(r_oe == 1'b0, "R1 oe off on write", 32'(r_oe), 0);
        cr(STAT[15:0], 6, "R8 low after write");
        cr(STAT[31:16], 7, "R7 high again");
        cr(STAT[15:0], 6, "R7 low after high");
        dr(16'h0000, 10, "R9 reset source comparand");
        cr(STAT[15:0], 6, "R8 low after data read");

        // R4 address-follow flag
        cw(16'h0800, 1, "R4 flag instruction");
        cw(16'h5A5A, 2, "R4 follow write to address");
        cw(16'h1001, 1, "R5 arm address override");
        cr(16'h5A5A, 2, "R4 address content");
        cw(16'h0800, 1, "R4 flag again");
        cr(STAT[15:0], 6, "R4 intervening read");
        cw(16'h0007, 1, "R4 flag cancelled");

        // R5 override sweep on writable targets
        for (int k = 1; k <= 3; k++) begin
            cw(16'h1000 | 16'(k), 1, "R5 arm");
            cw(16'hC000 + 16'(k) * 16'h0101, k + 1, "R5 override write");
            cw(16'h1000 | 16'(k), 1, "R5 rearm");
            dr(16'h0000, 10, "R5 data cycle keeps override");
            cr(16'hC000 + 16'(k) * 16'h0101, k + 1, "R5 override read");
            cr(STAT[15:0], 6, "R5 revert read");
            cw(16'h0000, 1, "R5 revert write");
        end

        // R6 next-free protection and read
        cw(16'h1004, 1, "R6 arm next-free");
        cw(16'hFFFF, -1, "R6 no load");
        cw(16'h1004, 1, "R6 arm next-free read");
        cr(16'h0000, 5, "R6 reset zero");
        @(negedge clk); nfa_set = 1'b1; nfa_val = 16'h0123;
        @(negedge clk); nfa_set = 1'b0;
        cw(16'h1004, 1, "R6 arm after update");
        cr(16'h0123, 5, "R6 updated value");
        cw(16'h1005, 1, "R10 arm source word");
        cw(16'hABCD, -1, "R6 select word no load");

        // R9 persistent selection sweep
        for (int d = 0; d < 3; d++) begin
            cw(16'h3000 | 16'(d), 1, "R9 select destination");
            dw(16'hA000 + 16'(d) * 16'h0111, 10 + d, "R9 data write");
        end
        for (int s = 0; s < 3; s++) begin
            cw(16'h2000 | 16'(s), 1, "R9 select source");
            dr(16'hA000 + 16'(s) * 16'h0111, 10 + s, "R9 data read");
        end
        cw(16'h3003, 1, "R9 invalid destination code");
        dw(16'h7777, 12, "R9 invalid ignored");
        dr(16'h7777, 12, "R9 stored via kept destination");
        cw(16'h3000, 1, "R9 back to comparand");
        dw(16'h1111, 10, "R9 comparand destination");

        // R10 select word readback
        cw(16'h1005, 1, "R10 arm source word");
        cr(16'h2002, 8, "R10 source word");
        cw(16'h1006, 1, "R10 arm destination word");
        cr(16'h3000, 9, "R10 destination word");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule